// File: doc/BRIEF.md
# Nibble I/O Port Unit

This unit sits on a 4-bit data bus and provides one input port and two 4-bit output registers. The caller selects a port with a 4-bit port number. The decoding is deliberately incomplete. Any port number reads the same input port. Each output register watches one active-low bit of the port number, so a single write can load one register, the other, or both.

The input port returns the levels of four pull-up pushbuttons. A pressed button reads as 0. The input port drives the bus only while a read is enabled, and otherwise releases it.

The LCD register feeds the upper four data lines of a character LCD that runs in 4-bit mode. The control register carries the LCD register-select line, the LCD enable line, a debug LED and a speaker bit. This unit does not sequence the LCD protocol. Software does that by writing the registers.

The bus carries single strobes, not a stream. A write is accepted on every clock edge where the strobe is high. There is no back-pressure and no ready signal.

Top module: `nib_io_ports`

## Requirements
- R1: After reset both output registers hold 0: `lcd_data`, `lcd_rs`, `lcd_en`, `led` and `spk` are all 0.
- R2: On a clock edge with `out_wr`=1 and `port_sel[0]`=0, the control register loads `wr_data`. The bit mapping is bit0 to `lcd_rs`, bit1 to `lcd_en`, bit2 to `led` and bit3 to `spk`.
- R3: On a clock edge with `out_wr`=1 and `port_sel[1]`=0, the LCD register loads `wr_data`, and `lcd_data[3:0]` shows it. `wr_data[3]` maps to LCD line D7 and `wr_data[0]` maps to D4.
- R4: When `port_sel[1:0]`=00 and `out_wr`=1, both registers load the same `wr_data` on the same edge.
- R5: `port_sel[3:2]` has no effect on which output register loads.
- R6: With `out_wr`=0, neither output register changes, whatever the values of `port_sel`, `wr_data` or `in_rd`.
- R7: While `in_rd`=1, `rd_drive`=1 and `rd_data` equals `buttons_n` in the same cycle, for any `port_sel`. A pressed button reads as 0.
- R8: While `in_rd`=0, `rd_drive`=0 and `rd_data`=0, so the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 4 | Port number from the instruction |
| out_wr | input | 1 | Output write strobe |
| wr_data | input | 4 | Data bus value to write |
| in_rd | input | 1 | Input read enable |
| buttons_n | input | 4 | Pushbutton levels, 0 = pressed |
| rd_data | output | 4 | Read value, 0 when not driving |
| rd_drive | output | 1 | High while the input port drives the bus |
| lcd_data | output | 4 | LCD data lines D7..D4 |
| lcd_rs | output | 1 | LCD register select |
| lcd_en | output | 1 | LCD enable |
| led | output | 1 | Debug LED |
| spk | output | 1 | Speaker bit |

## Verification
The directed writes use port numbers with exactly one of bits 1 and 0 low. These show that each register follows its own select bit. Port numbers with both bits low confirm the dual load, and numbers with both bits high confirm that neither register loads. The same low-bit patterns with different upper bits show that bits 3 and 2 are ignored. Reads with varied port numbers and button levels, and idle cycles with the strobe low, separate the read path and the hold behaviour from the write path. A long stretch of random stimulus then compares every output against a behavioural model on each clock.

// File: rtl/nib_io_pkg.sv
package nib_io_pkg;
  localparam int NIB_W   = 4;
  localparam int NUM_OUT = 2;

  // output register index equals the port-number bit that selects it
  typedef enum int { OUT_CTRL = 0, OUT_LCD = 1 } out_idx_e;

  typedef struct packed {
    logic spk;
    logic led;
    logic en;
    logic rs;
  } ctrl_bits_t;
endpackage

// File: rtl/nib_out_decode.sv
module nib_out_decode
  import nib_io_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic [PORT_W-1:0]  port_sel,
  input  logic               out_wr,
  output logic [NUM_OUT-1:0] load
);
  // each register answers to a single active-low select bit
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_sel
    assign load[i] = out_wr & ~port_sel[i];
  end
endmodule

// File: rtl/nib_out_reg.sv
module nib_out_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/nib_in_port.sv
module nib_in_port #(
  parameter int W = 4
) (
  input  logic         in_rd,
  input  logic [W-1:0] buttons_n,
  output logic [W-1:0] rd_data,
  output logic         rd_drive
);
  // no port-number input: every IN reads the buttons
  assign rd_drive = in_rd;
  assign rd_data  = in_rd ? buttons_n : '0;
endmodule

// File: rtl/nib_io_ports.sv
module nib_io_ports
  import nib_io_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_sel,
  input  logic              out_wr,
  input  logic [NIB_W-1:0]  wr_data,
  input  logic              in_rd,
  input  logic [NIB_W-1:0]  buttons_n,
  output logic [NIB_W-1:0]  rd_data,
  output logic              rd_drive,
  output logic [NIB_W-1:0]  lcd_data,
  output logic              lcd_rs,
  output logic              lcd_en,
  output logic              led,
  output logic              spk
);
  logic [NUM_OUT-1:0] load;
  logic [NIB_W-1:0]   out_q [NUM_OUT];
  ctrl_bits_t         ctrl;

  nib_out_decode #(.PORT_W(PORT_W)) u_dec (
    .port_sel(port_sel), .out_wr(out_wr), .load(load)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    nib_out_reg #(.W(NIB_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .load(load[i]), .d(wr_data), .q(out_q[i])
    );
  end

  nib_in_port #(.W(NIB_W)) u_in (
    .in_rd(in_rd), .buttons_n(buttons_n), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  assign ctrl     = ctrl_bits_t'(out_q[OUT_CTRL]);
  assign lcd_rs   = ctrl.rs;
  assign lcd_en   = ctrl.en;
  assign led      = ctrl.led;
  assign spk      = ctrl.spk;
  assign lcd_data = out_q[OUT_LCD];
endmodule

// File: rtl/nib_io_ports_chk.sv
module nib_io_ports_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] port_sel,
  input logic       out_wr,
  input logic [3:0] wr_data,
  input logic       in_rd,
  input logic [3:0] buttons_n,
  input logic [3:0] rd_data,
  input logic       rd_drive,
  input logic [3:0] lcd_data,
  input logic       lcd_rs,
  input logic       lcd_en,
  input logic       led,
  input logic       spk
);
  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && !port_sel[0]) |=> ({spk, led, lcd_en, lcd_rs} == $past(wr_data)));
  // R3
  lcd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && !port_sel[1]) |=> (lcd_data == $past(wr_data)));
  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_wr || port_sel[0]) |=> $stable({spk, led, lcd_en, lcd_rs}));
  // R6
  lcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_wr || port_sel[1]) |=> $stable(lcd_data));
  // R7
  read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd |-> (rd_drive && rd_data == buttons_n));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rd |-> (!rd_drive && rd_data == 4'h0));
endmodule

bind nib_io_ports nib_io_ports_chk i_chk (.*);

// File: tb/test_nib_io_ports.sv
module test_nib_io_ports;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] port_sel = 4'h0;
  logic       out_wr = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic       in_rd = 1'b0;
  logic [3:0] buttons_n = 4'hF;
  logic [3:0] rd_data, lcd_data;
  logic       rd_drive, lcd_rs, lcd_en, led, spk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [3:0] m_ctrl = 4'h0;
  logic [3:0] m_lcd  = 4'h0;

  nib_io_ports i_nib_io_ports (.*);

  always #2 clk = ~clk;

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check read path, clock, update model, check regs
  task automatic step(input logic [3:0] sel, input logic wr, input logic [3:0] d,
                      input logic rd, input logic [3:0] btn, input string tag);
    @(negedge clk);
    port_sel = sel; out_wr = wr; wr_data = d; in_rd = rd; buttons_n = btn;
    #1;
    if (rd) begin
      check("R7", "rd_drive", rd_drive, 1);
      check("R7", "rd_data", rd_data, btn);
    end else begin
      check("R8", "rd_drive", rd_drive, 0);
      check("R8", "rd_data", rd_data, 0);
    end
    @(posedge clk);
    if (wr && !sel[0]) m_ctrl = d;
    if (wr && !sel[1]) m_lcd  = d;
    #1;
    check(tag, "ctrl {spk,led,en,rs}", {spk, led, lcd_en, lcd_rs}, m_ctrl);
    check(tag, "lcd_data", lcd_data, m_lcd);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "lcd_data", lcd_data, 0);
    check("R1", "ctrl", {spk, led, lcd_en, lcd_rs}, 0);
    @(negedge clk) rst_n = 1'b1;

    step(4'b1110, 1'b1, 4'h5, 1'b0, 4'hF, "R2");  // ctrl only
    check("R2", "lcd_rs", lcd_rs, 1);
    check("R2", "led", led, 1);
    check("R2", "lcd_en", lcd_en, 0);
    step(4'b1110, 1'b1, 4'hA, 1'b0, 4'hF, "R2");
    check("R2", "spk", spk, 1);
    step(4'b1101, 1'b1, 4'h9, 1'b0, 4'hF, "R3");  // lcd only, D7 and D4 set
    check("R3", "lcd_data", lcd_data, 4'h9);
    step(4'b0000, 1'b1, 4'h3, 1'b0, 4'hF, "R4");  // both
    check("R4", "both equal", lcd_data, {spk, led, lcd_en, lcd_rs});
    step(4'b0011, 1'b1, 4'hC, 1'b0, 4'hF, "R5");  // neither
    step(4'b0010, 1'b1, 4'h6, 1'b0, 4'hF, "R5");  // ctrl despite upper bits
    step(4'b1001, 1'b1, 4'hE, 1'b0, 4'hF, "R5");  // lcd despite upper bits
    step(4'b0000, 1'b0, 4'h1, 1'b1, 4'h2, "R6");  // no strobe: hold
    step(4'b1100, 1'b0, 4'h7, 1'b0, 4'hF, "R6");
    step(4'b1111, 1'b0, 4'h0, 1'b1, 4'hE, "R7");  // reads, various ports
    step(4'b0101, 1'b0, 4'h0, 1'b1, 4'h0, "R7");
    step(4'b1010, 1'b0, 4'h0, 1'b0, 4'h0, "R8");

    for (int k = 0; k < 400; k++) begin
      step(4'($urandom), 1'($urandom), 4'($urandom), 1'($urandom), 4'($urandom), "R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule